// File: doc/BRIEF.md
# Bordered raster timing generator

This block produces the raster timing for a display controller. A horizontal counter steps once per pixel clock and wraps at a programmed line length. A vertical counter steps once per line and wraps at a programmed field length. The block compares the two counter values with programmed limits and drives six outputs: horizontal and vertical sync, a border-active flag, a window-active flag, a one-cycle vertical-blank pulse and a field-parity bit for interlaced output.

The visible area is a border rectangle. Outside that rectangle the sync/blank interval runs, starting at the border stop, wrapping past the end of the line or field, and ending at the border start. A display window sits inside the rectangle. It begins at its own horizontal and vertical start and extends to the border stop. A blanking control suppresses the window so that border colour fills the whole visible area. Line doubling repeats each line, and interlace toggles the field parity on every field.

Software programs the block through a write-only register port. Every write goes to a shadow set. The shadow set is copied into the active set at the first clock of vertical blank, so a frame is never drawn with a mix of old and new timing.

Top module: `raster_timing_gen`

## Requirements
- R1: Register 0 holds the field length in lines (bits 31:16) and the line length in clocks (bits 15:0). The horizontal position counts 0 to line length − 1. The vertical position counts 0 to field length − 1 and steps once per line. A progressive frame lasts line length × field length clocks.
- R2: Register 1 holds the horizontal border start in bits 31:16 and the horizontal border stop in bits 15:0. Register 2 holds the vertical border start and stop in the same layout. border_o is high exactly when start ≤ position < stop on both axes and output is enabled (R6).
- R3: hsync_o is high whenever the horizontal position lies outside [horizontal border start, stop). vsync_o is high whenever the vertical position lies outside [vertical border start, stop). Both interval ends wrap around the end of the line or field.
- R4: Register 3 holds the window vertical start in bits 31:16 and the window horizontal start in bits 15:0. window_o is high when border_o is high and both positions are at or past the window starts.
- R5: When bit 3 of register 5 is set, window_o stays low and border_o is unchanged, so border colour covers the visible area.
- R6: border_o and window_o can be high only when bit 0 of register 4 (display enable) and bit 8 of register 6 (video enable) are both set. The syncs and counters run regardless of these bits.
- R7: When bit 1 of register 4 is set, each line is output twice: the vertical position steps every second line, and a frame lasts 2 × line length × field length clocks.
- R8: When bit 4 of register 6 is set, field_o toggles each time the vertical position wraps to 0. When the bit is clear, field_o is 0.
- R9: vblank_o is a one-cycle pulse. It is high in the clock where the horizontal position is 0, the line is on its first repeat, and the vertical position equals the vertical border stop in force for the frame just finished.
- R10: Register writes change no output until the next vblank_o pulse. The complete written set takes effect in the same clock as that pulse.
- R11: clk_dbl_o follows bit 23 of register 4. pix_dbl_o follows bit 0 of register 5. border_rgb_o follows register 7 bits 23:0. All three are taken from the active set.
- R12: After reset, both positions are 0, field_o and vblank_o are 0, and every configuration field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register index |
| wr_data_i | input | DATA_W | Register write data |
| hsync_o | output | 1 | Horizontal sync/blank interval |
| vsync_o | output | 1 | Vertical sync/blank interval |
| border_o | output | 1 | Inside the border rectangle |
| window_o | output | 1 | Inside the display window |
| vblank_o | output | 1 | One-cycle pulse at start of vertical blank |
| field_o | output | 1 | Interlace field parity |
| clk_dbl_o | output | 1 | Doubled pixel clock select |
| pix_dbl_o | output | 1 | Horizontal pixel doubling |
| border_rgb_o | output | 24 | Border colour |

## Verification
The assertions check the following on every cycle:
- the horizontal position stays below the line length;
- the vertical-blank pulse lasts one cycle and falls on a line start;
- the field bit moves only at the field origin;
- the active configuration stays frozen between loads;
- the enable pair gates the visible flags.

Other behaviours need whole-frame references from a model, and only the bench scenarios show them. These are the exact placement of the border, window and sync regions, the frame lengths with and without line doubling, and the deferral of register writes to the next blank.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int POS_W      = 16;
    localparam int COLOR_W    = 24;
    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 32;
    localparam int HI_LSB     = 16;

    // register indices
    localparam int A_TOTALS   = 0;
    localparam int A_HBORDER  = 1;
    localparam int A_VBORDER  = 2;
    localparam int A_WINPOS   = 3;
    localparam int A_MODE     = 4;
    localparam int A_WINCFG   = 5;
    localparam int A_SYNCCFG  = 6;
    localparam int A_BORDRGB  = 7;

    // control bit positions
    localparam int B_DISP_EN  = 0;
    localparam int B_SCAN_DBL = 1;
    localparam int B_CLK_DBL  = 23;
    localparam int B_PIX_DBL  = 0;
    localparam int B_BLANK    = 3;
    localparam int B_INTERLACE = 4;
    localparam int B_VIDEO_EN = 8;

    typedef struct packed {
        logic [POS_W-1:0]   htot;
        logic [POS_W-1:0]   vtot;
        logic [POS_W-1:0]   hb_start;
        logic [POS_W-1:0]   hb_stop;
        logic [POS_W-1:0]   vb_start;
        logic [POS_W-1:0]   vb_stop;
        logic [POS_W-1:0]   win_h;
        logic [POS_W-1:0]   win_v;
        logic               disp_en;
        logic               scan_dbl;
        logic               clk_dbl;
        logic               pix_dbl;
        logic               blank;
        logic               interlace;
        logic               video_en;
        logic [COLOR_W-1:0] border_rgb;
    } rtg_cfg_t;
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
    import rtg_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_i,
    output rtg_cfg_t          active_o
);
    typedef struct packed {
        rtg_cfg_t shadow;
        rtg_cfg_t active;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic [POS_W-1:0] hi_w, lo_w;
    logic unused_wdata;

    assign hi_w = wr_data_i[HI_LSB +: POS_W];
    assign lo_w = wr_data_i[POS_W-1:0];
    assign unused_wdata = ^wr_data_i;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) nxt_d.active = cur_q.shadow;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_W'(A_TOTALS):  begin nxt_d.shadow.vtot = hi_w;     nxt_d.shadow.htot = lo_w;    end
                ADDR_W'(A_HBORDER): begin nxt_d.shadow.hb_start = hi_w; nxt_d.shadow.hb_stop = lo_w; end
                ADDR_W'(A_VBORDER): begin nxt_d.shadow.vb_start = hi_w; nxt_d.shadow.vb_stop = lo_w; end
                ADDR_W'(A_WINPOS):  begin nxt_d.shadow.win_v = hi_w;    nxt_d.shadow.win_h = lo_w;   end
                ADDR_W'(A_MODE): begin
                    nxt_d.shadow.disp_en  = wr_data_i[B_DISP_EN];
                    nxt_d.shadow.scan_dbl = wr_data_i[B_SCAN_DBL];
                    nxt_d.shadow.clk_dbl  = wr_data_i[B_CLK_DBL];
                end
                ADDR_W'(A_WINCFG): begin
                    nxt_d.shadow.pix_dbl = wr_data_i[B_PIX_DBL];
                    nxt_d.shadow.blank   = wr_data_i[B_BLANK];
                end
                ADDR_W'(A_SYNCCFG): begin
                    nxt_d.shadow.interlace = wr_data_i[B_INTERLACE];
                    nxt_d.shadow.video_en  = wr_data_i[B_VIDEO_EN];
                end
                ADDR_W'(A_BORDRGB): nxt_d.shadow.border_rgb = wr_data_i[COLOR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign active_o = cur_q.active;

    assert_active_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(active_o))
        else $error("active set changed without a load");
endmodule

// File: rtl/rtg_scan_ctr.sv
module rtg_scan_ctr
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  rtg_cfg_t         cfg_i,
    output logic [POS_W-1:0] hpos_o,
    output logic [POS_W-1:0] vpos_o,
    output logic             field_o,
    output logic             vblank_o,
    output logic             load_o
);
    typedef struct packed {
        logic [POS_W-1:0] h;
        logic [POS_W-1:0] v;
        logic             rep;
        logic             field;
        logic             vblank;
    } ctr_t;

    ctr_t cur_q, nxt_d;
    logic [POS_W:0]   h_inc, v_inc;
    logic             line_end, adv_v, v_wrap, event_w;
    logic [POS_W-1:0] v_next;
    logic unused_cfg;

    assign unused_cfg = ^cfg_i;

    always_comb begin
        nxt_d    = cur_q;
        h_inc    = {1'b0, cur_q.h} + (POS_W+1)'(1);
        v_inc    = {1'b0, cur_q.v} + (POS_W+1)'(1);
        line_end = h_inc >= {1'b0, cfg_i.htot};
        adv_v    = line_end && !(cfg_i.scan_dbl && !cur_q.rep);
        v_wrap   = v_inc >= {1'b0, cfg_i.vtot};
        v_next   = v_wrap ? '0 : v_inc[POS_W-1:0];
        event_w  = adv_v && (v_next == cfg_i.vb_stop);

        nxt_d.h = line_end ? '0 : h_inc[POS_W-1:0];
        if (line_end) nxt_d.rep = cfg_i.scan_dbl && !cur_q.rep;
        if (adv_v)    nxt_d.v   = v_next;
        if (!cfg_i.interlace)     nxt_d.field = 1'b0;
        else if (adv_v && v_wrap) nxt_d.field = ~cur_q.field;
        nxt_d.vblank = event_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign hpos_o   = cur_q.h;
    assign vpos_o   = cur_q.v;
    assign field_o  = cur_q.field;
    assign vblank_o = cur_q.vblank;
    assign load_o   = event_w;

    assert_hpos_below_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.htot != '0) |-> (cur_q.h < cfg_i.htot))
        else $error("horizontal position beyond line length");

    assert_vblank_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.vblank && cfg_i.htot > POS_W'(1)) |=> !cur_q.vblank)
        else $error("vblank pulse longer than one cycle");

    assert_vblank_line_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.vblank |-> (cur_q.h == '0 && !cur_q.rep))
        else $error("vblank pulse away from line start");

    assert_field_at_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_q.field) && cfg_i.interlace) |-> (cur_q.h == '0 && cur_q.v == '0))
        else $error("field parity moved away from field origin");
endmodule

// File: rtl/rtg_region.sv
module rtg_region
    import rtg_pkg::*;
(
    input  logic [POS_W-1:0] hpos_i,
    input  logic [POS_W-1:0] vpos_i,
    input  rtg_cfg_t         cfg_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             border_o,
    output logic             window_o
);
    logic h_in, v_in, enabled;
    logic unused_cfg;

    assign unused_cfg = ^cfg_i;

    always_comb begin
        h_in     = (hpos_i >= cfg_i.hb_start) && (hpos_i < cfg_i.hb_stop);
        v_in     = (vpos_i >= cfg_i.vb_start) && (vpos_i < cfg_i.vb_stop);
        enabled  = cfg_i.disp_en && cfg_i.video_en;
        hsync_o  = !h_in;
        vsync_o  = !v_in;
        border_o = enabled && h_in && v_in;
        window_o = border_o && !cfg_i.blank &&
                   (hpos_i >= cfg_i.win_h) && (vpos_i >= cfg_i.win_v);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W,
    parameter int DATA_W = REG_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               border_o,
    output logic               window_o,
    output logic               vblank_o,
    output logic               field_o,
    output logic               clk_dbl_o,
    output logic               pix_dbl_o,
    output logic [COLOR_W-1:0] border_rgb_o
);
    rtg_cfg_t         active_cfg;
    logic             load_w;
    logic [POS_W-1:0] hpos_w, vpos_w;

    rtg_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .load_i(load_w), .active_o(active_cfg)
    );

    rtg_scan_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .cfg_i(active_cfg), .hpos_o(hpos_w),
        .vpos_o(vpos_w), .field_o(field_o), .vblank_o(vblank_o), .load_o(load_w)
    );

    rtg_region u_region (
        .hpos_i(hpos_w), .vpos_i(vpos_w), .cfg_i(active_cfg),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .border_o(border_o), .window_o(window_o)
    );

    assign clk_dbl_o    = active_cfg.clk_dbl;
    assign pix_dbl_o    = active_cfg.pix_dbl;
    assign border_rgb_o = active_cfg.border_rgb;

    assert_enables_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_cfg.disp_en && active_cfg.video_en) |-> (!border_o && !window_o))
        else $error("visible flag with output disabled");
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    import rtg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [REG_ADDR_W-1:0] wr_addr = '0;
    logic [REG_DATA_W-1:0] wr_data = '0;
    logic hsync, vsync, border, window, vblank, field, clk_dbl, pix_dbl;
    logic [COLOR_W-1:0] border_rgb;

    always #5 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .hsync_o(hsync), .vsync_o(vsync), .border_o(border), .window_o(window),
        .vblank_o(vblank), .field_o(field), .clk_dbl_o(clk_dbl), .pix_dbl_o(pix_dbl),
        .border_rgb_o(border_rgb)
    );

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench view of the programmed timing
    int b_htot = 20, b_vtot = 12, b_hbs = 4, b_hbe = 18, b_vbs = 2, b_vbe = 10;
    int b_wh = 8, b_wv = 4;
    bit b_disp = 1, b_vid = 1, b_blank = 0, b_dbl = 0, b_intl = 0;
    int m_h, m_v;
    bit m_rep, m_field;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = REG_ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_vb(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!vblank && n < 5000);
        check(vblank == 1'b1, {req, " vblank pulse arrives"}, vblank, 1);
    endtask

    task automatic sweep(input int n, input string req);
        int e_hs = 0, e_vs = 0, e_bd = 0, e_wn = 0, e_vb = 0, e_fd = 0, n_win = 0;
        bit hin, vin, xb, xw;
        m_h = 0; m_v = b_vbe; m_rep = 0; m_field = field;
        for (int i = 0; i < n; i++) begin
            hin = (m_h >= b_hbs) && (m_h < b_hbe);
            vin = (m_v >= b_vbs) && (m_v < b_vbe);
            xb  = b_disp && b_vid && hin && vin;
            xw  = xb && !b_blank && (m_h >= b_wh) && (m_v >= b_wv);
            if (hsync  !== !hin) e_hs++;
            if (vsync  !== !vin) e_vs++;
            if (border !== xb)   e_bd++;
            if (window !== xw)   e_wn++;
            if (window) n_win++;
            if (vblank !== (m_h == 0 && m_v == b_vbe && !m_rep)) e_vb++;
            if (field  !== m_field) e_fd++;
            m_h++;
            if (m_h == b_htot) begin
                m_h = 0;
                if (b_dbl && !m_rep) m_rep = 1;
                else begin
                    m_rep = 0;
                    m_v++;
                    if (m_v == b_vtot) begin
                        m_v = 0;
                        if (b_intl) m_field = ~m_field;
                    end
                end
            end
            @(negedge clk);
        end
        check(e_hs == 0, {req, " R3 hsync mismatches"}, e_hs, 0);
        check(e_vs == 0, {req, " R3 vsync mismatches"}, e_vs, 0);
        check(e_bd == 0, {req, " R2 border mismatches"}, e_bd, 0);
        check(e_wn == 0, {req, " R4 window mismatches"}, e_wn, 0);
        check(e_vb == 0, {req, " R9 vblank mismatches"}, e_vb, 0);
        check(e_fd == 0, {req, " R8 field mismatches"}, e_fd, 0);
        check(vblank == 1'b1, {req, " R1 next frame starts on time"}, vblank, 1);
        if (b_disp && b_vid && !b_blank)
            check(n_win > 0, {req, " R4 window seen"}, n_win, 1);
    endtask

    task automatic t_reset;
        check(border == 0, "R12 border in reset", border, 0);
        check(window == 0, "R12 window in reset", window, 0);
        check(vblank == 0, "R12 vblank in reset", vblank, 0);
        check(field == 0, "R12 field in reset", field, 0);
        check(clk_dbl == 0 && pix_dbl == 0, "R12 mode outputs in reset", {clk_dbl, pix_dbl}, 0);
        check(border_rgb == 0, "R12 colour in reset", border_rgb, 0);
    endtask

    task automatic t_progressive;
        wr(A_TOTALS,  32'h000C_0014);
        wr(A_HBORDER, 32'h0004_0012);
        wr(A_VBORDER, 32'h0002_000A);
        wr(A_WINPOS,  32'h0004_0008);
        wr(A_MODE,    32'h0000_0001);
        wr(A_SYNCCFG, 32'h0000_0100);
        wr(A_BORDRGB, 32'h0012_3456);
        wait_vb("R10 program");
        wait_vb("R9 program");
        sweep(b_htot * b_vtot, "R1 R2 progressive");
    endtask

    task automatic t_blank;
        wr(A_WINCFG, 32'h0000_0008);
        wait_vb("R5 blank");
        b_blank = 1;
        sweep(b_htot * b_vtot, "R5 blank");
        wr(A_WINCFG, 32'h0);
        wr(A_MODE, 32'h0);
        wait_vb("R6 disp off");
        b_blank = 0; b_disp = 0;
        sweep(b_htot * b_vtot, "R6 display off");
    endtask

    task automatic t_enable;
        wr(A_MODE, 32'h1);
        wr(A_SYNCCFG, 32'h0);
        wait_vb("R6 video off");
        b_disp = 1; b_vid = 0;
        sweep(b_htot * b_vtot, "R6 video off");
    endtask

    task automatic t_scan_double;
        wr(A_SYNCCFG, 32'h100);
        wr(A_MODE, 32'h3);
        wait_vb("R7 double");
        b_vid = 1; b_dbl = 1;
        sweep(2 * b_htot * b_vtot, "R7 scan double");
    endtask

    task automatic t_interlace;
        wr(A_MODE, 32'h1);
        wr(A_SYNCCFG, 32'h110);
        wait_vb("R8 interlace");
        b_dbl = 0; b_intl = 1;
        sweep(2 * b_htot * b_vtot, "R8 interlace");
    endtask

    task automatic t_shadow;
        int t0, t1, t2;
        t0 = cyc;
        wr(A_SYNCCFG, 32'h100);
        wr(A_MODE, 32'h0080_0001);
        wr(A_WINCFG, 32'h1);
        wr(A_TOTALS, 32'h000C_0018);
        check(clk_dbl == 0, "R10 clock select held before blank", clk_dbl, 0);
        check(pix_dbl == 0, "R10 pixel doubling held before blank", pix_dbl, 0);
        wait_vb("R10 shadow");
        t1 = cyc;
        check(t1 - t0 == 240, "R10 old frame length kept", t1 - t0, 240);
        check(clk_dbl == 1, "R11 clock select", clk_dbl, 1);
        check(pix_dbl == 1, "R11 pixel doubling", pix_dbl, 1);
        check(border_rgb == 24'h123456, "R11 border colour", border_rgb, 24'h123456);
        wait_vb("R1 new total");
        t2 = cyc;
        check(t2 - t1 == 288, "R1 new frame length", t2 - t1, 288);
        check(field == 0, "R8 field cleared when interlace off", field, 0);
    endtask

    bit done = 0;
    initial begin
        #1_500_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_progressive();
        t_blank();
        t_enable();
        t_scan_double();
        t_interlace();
        t_shadow();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule